// File: doc/BRIEF.md
# Sixteen-Pin GPIO Bank with Interrupt Capture

This block is one bank of general-purpose pins for a peripheral subsystem. Software uses a small synchronous register bus to configure it. Each pin has a direction, a driven level, an alternate-function select, an interrupt mask, and a trigger selection. The trigger selection picks edge or level detection and the active polarity. The bank samples its input pins through a two-stage synchronizer. Detected conditions are caught in a sticky status register, which software clears by writing ones. A single interrupt line goes high while any unmasked status bit is set.

The bank also handles two low-power conditions. While a sleep request is present, pins not excluded by a sleep mask drive programmed sleep levels. Software can also force those sleep levels on without a sleep request. While a battery-fault request is present, every pin drives its programmed fault level, and this overrides sleep.

The bus is addressed by word index. The byte offset is four times the index. Reads are combinational from the index. Writes take effect at the clock edge.

Top module: `gpio_irq_bank`

## Requirements
- R1: During reset, the interrupt mask reads 0xFFFF and every other register reads 0. In that state `pin_o`, `pin_oe_o`, `alt_sel_o` and `irq_o` are all 0.
- R2: The following indices hold all 16 written bits and read them back:
  - 0 mask
  - 1 direction
  - 2 output
  - 3 trigger kind
  - 4 edge polarity
  - 5 level polarity
  - 6 sleep exclusion
  - 7 sleep level
  - 8 fault level
  - 10 alternate select
- R2 (continued): Index 11 keeps only bit 1 and reads 0 elsewhere. Indices 13 to 15 read 0 and ignore writes.
- R3: `pin_oe_o` equals the direction register (1 = drive). `alt_sel_o` equals the alternate register. With no sleep or fault in force, `pin_o` equals the output register.
- R4: Index 12 is read-only. It returns `pin_i` as sampled by two flops, so a pin change made between edges k and k+1 reads back after edge k+2. Writes to index 12 are ignored.
- R5: A trigger-kind bit of 1 selects edge detection. Polarity 1 catches a 0-to-1 change of the synchronized sample and polarity 0 catches a 1-to-0 change. The status bit is set at the third edge after the pin change.
- R6: A trigger-kind bit of 0 selects level detection. The status bit is set on every edge at which the synchronized sample equals the level-polarity bit, so a cleared bit sets again while the level persists.
- R7: Writing index 9 clears the status bits written as 1 and leaves the rest. A detection at the same edge as the clear keeps the bit set.
- R8: `irq_o` is 1 exactly when some status bit is set whose mask bit is 0.
- R9: While `sleep_i` is 1 and `batt_fault_i` is 0, each pin with sleep-exclusion bit 0 drives its sleep level. Pins with sleep-exclusion bit 1 drive the output register.
- R10: With bit 1 of index 11 set, the sleep levels apply exactly as in R9 even when `sleep_i` is 0.
- R11: While `batt_fault_i` is 1, every pin drives its fault level, whatever the state of sleep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register word index |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` |
| pin_i | input | 16 | Input pin levels |
| pin_o | output | 16 | Driven pin levels |
| pin_oe_o | output | 16 | Per-pin drive enable |
| alt_sel_o | output | 16 | Per-pin alternate-function select |
| sleep_i | input | 1 | Sleep request |
| batt_fault_i | input | 1 | Battery-fault request |
| irq_o | output | 1 | Bank interrupt |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a status clear and a fresh detection on the same bit. The bench provokes this by changing a pin and timing the index-9 write so that it lands on the third edge after the change. Random traffic also produces the collision on level-triggered pins. In both cases the outcome is judged against a model in which the detection survives the clear.

The second pair is a battery fault and a sleep request, either an explicit one or one forced through the sleep-config bit. The bench raises them together and compares every pin against the fault levels.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned IDX_W         = 4;
  localparam int unsigned AUTOSLEEP_BIT = 1;

  typedef enum logic [IDX_W-1:0] {
    REG_MASK     = 4'd0,
    REG_DIR      = 4'd1,
    REG_OUT      = 4'd2,
    REG_TRIG     = 4'd3,
    REG_EDGE_POL = 4'd4,
    REG_LVL_POL  = 4'd5,
    REG_SLP_EXCL = 4'd6,
    REG_SLP_LVL  = 4'd7,
    REG_BF_LVL   = 4'd8,
    REG_STATUS   = 4'd9,
    REG_ALT      = 4'd10,
    REG_SLP_CFG  = 4'd11,
    REG_PIN      = 4'd12
  } reg_idx_e;
endpackage

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic                we_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  input  logic [NUM_PINS-1:0] status_i,
  input  logic [NUM_PINS-1:0] pin_sync_i,
  output logic [NUM_PINS-1:0] clr_o,
  output logic [NUM_PINS-1:0] mask_o,
  output logic [NUM_PINS-1:0] dir_o,
  output logic [NUM_PINS-1:0] out_o,
  output logic [NUM_PINS-1:0] trig_o,
  output logic [NUM_PINS-1:0] epol_o,
  output logic [NUM_PINS-1:0] lpol_o,
  output logic [NUM_PINS-1:0] sexcl_o,
  output logic [NUM_PINS-1:0] slvl_o,
  output logic [NUM_PINS-1:0] bflvl_o,
  output logic [NUM_PINS-1:0] alt_o,
  output logic                autosleep_o
);
  logic [NUM_PINS-1:0] mask_q, dir_q, out_q, trig_q, epol_q, lpol_q;
  logic [NUM_PINS-1:0] sexcl_q, slvl_q, bflvl_q, alt_q;
  logic                autosleep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q      <= '1;
      dir_q       <= '0;
      out_q       <= '0;
      trig_q      <= '0;
      epol_q      <= '0;
      lpol_q      <= '0;
      sexcl_q     <= '0;
      slvl_q      <= '0;
      bflvl_q     <= '0;
      alt_q       <= '0;
      autosleep_q <= 1'b0;
    end else if (we_i) begin
      case (reg_idx_e'(idx_i))
        REG_MASK:     mask_q      <= wdata_i;
        REG_DIR:      dir_q       <= wdata_i;
        REG_OUT:      out_q       <= wdata_i;
        REG_TRIG:     trig_q      <= wdata_i;
        REG_EDGE_POL: epol_q      <= wdata_i;
        REG_LVL_POL:  lpol_q      <= wdata_i;
        REG_SLP_EXCL: sexcl_q     <= wdata_i;
        REG_SLP_LVL:  slvl_q      <= wdata_i;
        REG_BF_LVL:   bflvl_q     <= wdata_i;
        REG_ALT:      alt_q       <= wdata_i;
        REG_SLP_CFG:  autosleep_q <= wdata_i[AUTOSLEEP_BIT];
        default: ;
      endcase
    end
  end

  // write-one-to-clear strobe toward the status logic
  assign clr_o = (we_i && (idx_i == REG_STATUS)) ? wdata_i : '0;

  always_comb begin
    rdata_o = '0;
    case (reg_idx_e'(idx_i))
      REG_MASK:     rdata_o = mask_q;
      REG_DIR:      rdata_o = dir_q;
      REG_OUT:      rdata_o = out_q;
      REG_TRIG:     rdata_o = trig_q;
      REG_EDGE_POL: rdata_o = epol_q;
      REG_LVL_POL:  rdata_o = lpol_q;
      REG_SLP_EXCL: rdata_o = sexcl_q;
      REG_SLP_LVL:  rdata_o = slvl_q;
      REG_BF_LVL:   rdata_o = bflvl_q;
      REG_STATUS:   rdata_o = status_i;
      REG_ALT:      rdata_o = alt_q;
      REG_SLP_CFG:  rdata_o[AUTOSLEEP_BIT] = autosleep_q;
      REG_PIN:      rdata_o = pin_sync_i;
      default:      rdata_o = '0;
    endcase
  end

  assign mask_o      = mask_q;
  assign dir_o       = dir_q;
  assign out_o       = out_q;
  assign trig_o      = trig_q;
  assign epol_o      = epol_q;
  assign lpol_o      = lpol_q;
  assign sexcl_o     = sexcl_q;
  assign slvl_o      = slvl_q;
  assign bflvl_o     = bflvl_q;
  assign alt_o       = alt_q;
  assign autosleep_o = autosleep_q;

  p_dir_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (idx_i == REG_DIR)) |=> (dir_o == $past(wdata_i)));

  p_pin_ro_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (idx_i == REG_PIN)) |=> ($stable(mask_o) && $stable(out_o) && $stable(alt_o)));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned NUM_PINS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] trig_i,
  input  logic [NUM_PINS-1:0] epol_i,
  input  logic [NUM_PINS-1:0] lpol_i,
  input  logic [NUM_PINS-1:0] mask_i,
  input  logic [NUM_PINS-1:0] clr_i,
  output logic [NUM_PINS-1:0] status_o,
  output logic [NUM_PINS-1:0] pin_sync_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] s1_q, s2_q, prev_q, status_q, det;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    assign det[g] = trig_i[g] ? ((s2_q[g] != prev_q[g]) && (s2_q[g] == epol_i[g]))
                              : (s2_q[g] == lpol_i[g]);
  end

  // detection beats a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | det;
  end

  assign status_o   = status_q;
  assign pin_sync_o = s2_q;
  assign irq_o      = |(status_q & ~mask_i);

  p_status_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(status_q) & ~$past(clr_i)) & ~status_q) == '0));

  p_edge_needs_change_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & ~$past(status_q) & $past(trig_i) & ~$past(s2_q ^ prev_q)) == '0));

  p_clear_no_det_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_i) |=> ((status_q & $past(clr_i & ~det)) == '0));
endmodule

// File: rtl/gpio_out_ctrl.sv
module gpio_out_ctrl #(
  parameter int unsigned NUM_PINS = 16
) (
  input  logic [NUM_PINS-1:0] out_i,
  input  logic [NUM_PINS-1:0] sexcl_i,
  input  logic [NUM_PINS-1:0] slvl_i,
  input  logic [NUM_PINS-1:0] bflvl_i,
  input  logic                sleep_i,
  input  logic                autosleep_i,
  input  logic                batt_fault_i,
  output logic [NUM_PINS-1:0] pin_o
);
  logic sleep_on;
  assign sleep_on = sleep_i | autosleep_i;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_mux
    assign pin_o[g] = batt_fault_i             ? bflvl_i[g] :
                      (sleep_on && !sexcl_i[g]) ? slvl_i[g]  : out_i[g];
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [IDX_W-1:0]    addr_i,
  input  logic                we_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic [NUM_PINS-1:0] alt_sel_o,
  input  logic                sleep_i,
  input  logic                batt_fault_i,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] status, pin_sync, clr, mask, dir, out_lvl, trig, epol, lpol;
  logic [NUM_PINS-1:0] sexcl, slvl, bflvl, alt;
  logic                autosleep;

  gpio_bank_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .idx_i       (addr_i),
    .we_i        (we_i),
    .wdata_i     (wdata_i),
    .rdata_o     (rdata_o),
    .status_i    (status),
    .pin_sync_i  (pin_sync),
    .clr_o       (clr),
    .mask_o      (mask),
    .dir_o       (dir),
    .out_o       (out_lvl),
    .trig_o      (trig),
    .epol_o      (epol),
    .lpol_o      (lpol),
    .sexcl_o     (sexcl),
    .slvl_o      (slvl),
    .bflvl_o     (bflvl),
    .alt_o       (alt),
    .autosleep_o (autosleep)
  );

  gpio_irq_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (pin_i),
    .trig_i     (trig),
    .epol_i     (epol),
    .lpol_i     (lpol),
    .mask_i     (mask),
    .clr_i      (clr),
    .status_o   (status),
    .pin_sync_o (pin_sync),
    .irq_o      (irq_o)
  );

  gpio_out_ctrl #(.NUM_PINS(NUM_PINS)) u_out (
    .out_i        (out_lvl),
    .sexcl_i      (sexcl),
    .slvl_i       (slvl),
    .bflvl_i      (bflvl),
    .sleep_i      (sleep_i),
    .autosleep_i  (autosleep),
    .batt_fault_i (batt_fault_i),
    .pin_o        (pin_o)
  );

  assign pin_oe_o  = dir;
  assign alt_sel_o = alt;

  p_fault_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    batt_fault_i |-> (pin_o == bflvl));

  p_sleep_levels_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && !batt_fault_i) |-> (((pin_o ^ slvl) & ~sexcl) == '0));

  p_irq_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == '1) |-> !irq_o);
endmodule

// File: tb/tb_gpio_irq_bank.sv
module tb_gpio_irq_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 16;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic [3:0]    addr;
  logic          we;
  logic [NP-1:0] wdata, rdata, pin_in, pin_out, pin_oe, alt_sel;
  logic          sleep, batt, irq;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  logic [NP-1:0] mreg [0:12];
  logic [NP-1:0] mstat;
  logic [NP-1:0] hist [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_bank #(.NUM_PINS(NP)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pin_in), .pin_o(pin_out), .pin_oe_o(pin_oe),
    .alt_sel_o(alt_sel), .sleep_i(sleep), .batt_fault_i(batt), .irq_o(irq)
  );

  task automatic model_reset();
    for (int i = 0; i < 13; i++) mreg[i] = '0;
    mreg[0] = '1;
    mstat = '0;
    hist = '{16'h0, 16'h0, 16'h0};
  endtask

  function automatic logic [NP-1:0] exp_rdata(int idx);
    if (idx <= 8 || idx == 10) return mreg[idx];
    if (idx == 9) return mstat;
    if (idx == 11) return mreg[11] & 16'h0002;
    if (idx == 12) return hist[1];
    return '0;
  endfunction

  function automatic logic [NP-1:0] exp_pins();
    logic [NP-1:0] r;
    bit sl;
    sl = sleep || mreg[11][1];
    for (int b = 0; b < NP; b++) begin
      if (batt)                    r[b] = mreg[8][b];
      else if (sl && !mreg[6][b])  r[b] = mreg[7][b];
      else                         r[b] = mreg[2][b];
    end
    return r;
  endfunction

  task automatic chk(string what, logic [NP-1:0] act, logic [NP-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act %h exp %h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("rdata", rdata, exp_rdata(int'(addr)));
    chk("pin_o", pin_out, exp_pins());
    chk("pin_oe", pin_oe, mreg[1]);
    chk("alt_sel", alt_sel, mreg[10]);
    chk("irq", {15'b0, irq}, {15'b0, |(mstat & ~mreg[0])});
  endtask

  task automatic model_commit();
    logic [NP-1:0] det, clr;
    logic [NP-1:0] cur, old;
    cur = hist[1];
    old = hist[2];
    for (int b = 0; b < NP; b++) begin
      if (mreg[3][b]) det[b] = (cur[b] != old[b]) && (cur[b] == mreg[4][b]);
      else            det[b] = (cur[b] == mreg[5][b]);
    end
    clr = (we && addr == 4'd9) ? wdata : '0;
    mstat = (mstat & ~clr) | det;
    if (we) begin
      if (addr <= 4'd8 || addr == 4'd10) mreg[addr] = wdata;
      else if (addr == 4'd11) mreg[11] = wdata & 16'h0002;
    end
    hist.push_front(pin_in);
    void'(hist.pop_back());
  endtask

  task automatic cycle();
    @(negedge clk);
    compare_all();
    model_commit();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(int idx, logic [NP-1:0] d);
    addr = 4'(idx); we = 1'b1; wdata = d;
    cycle();
    we = 1'b0;
  endtask

  task automatic rd(int idx);
    addr = 4'(idx);
    cycle();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog expired act 0 exp 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; addr = '0; we = 1'b0; wdata = '0; pin_in = '0;
    sleep = 1'b0; batt = 1'b0;
    model_reset();
    repeat (2) @(posedge clk);
    // R1: reset values on every index
    cur_req = "R1";
    for (int i = 0; i < 13; i++) begin
      addr = 4'(i);
      #1;
      compare_all();
    end
    @(posedge clk); #1;
    rst_ni = 1'b1;
    addr = '0;

    // R2: read-back, sleep-config bit masking, unmapped indices
    cur_req = "R2";
    for (int i = 0; i < 11; i++) begin
      if (i == 9) continue;
      wr(i, 16'hA55A ^ NP'(i * 16'h1111));
      rd(i);
    end
    wr(11, 16'hFFFF); rd(11);
    wr(11, 16'h0000); rd(11);
    wr(13, 16'hFFFF); rd(13);
    wr(15, 16'h1234); rd(15);
    // R4: index 12 ignores writes
    cur_req = "R4";
    wr(12, 16'hFFFF); rd(12);

    // R3: direction, output, alternate select
    cur_req = "R3";
    wr(1, 16'hA5A5); wr(2, 16'h3C3C); wr(10, 16'h00FF); wr(6, 16'h0000);
    repeat (2) cycle();

    // R4: synchronized pin readback, two-edge latency
    cur_req = "R4";
    wr(0, 16'hFFFF);
    addr = 4'd12;
    pin_in = 16'h1357; repeat (4) cycle();
    pin_in = 16'hFACE; repeat (4) cycle();

    // R5: edges, rising on low byte, falling on high byte
    cur_req = "R5";
    wr(3, 16'hFFFF); wr(4, 16'h00FF); wr(0, 16'h0000);
    pin_in = 16'h0000; repeat (4) cycle();
    wr(9, 16'hFFFF);
    addr = 4'd9;
    pin_in = 16'hFFFF; repeat (4) cycle();
    wr(9, 16'hFFFF); addr = 4'd9; repeat (2) cycle();
    pin_in = 16'h0000; repeat (4) cycle();

    // R6: level detection, re-set while level present
    cur_req = "R6";
    wr(3, 16'h0000); wr(5, 16'hF0F0);
    pin_in = 16'h00FF; repeat (4) cycle();
    wr(9, 16'hFFFF); addr = 4'd9; repeat (3) cycle();
    pin_in = 16'hFF00; repeat (4) cycle();

    // R7: clear lands on the same edge as a new detection
    cur_req = "R7";
    wr(3, 16'hFFFF); wr(4, 16'hFFFF);
    pin_in = 16'h0000; repeat (4) cycle();
    wr(9, 16'hFFFF); addr = 4'd9; cycle();
    pin_in = 16'h0001;
    cycle(); cycle();
    wr(9, 16'h0003);
    rd(9);
    wr(9, 16'h0001); rd(9);

    // R8: mask gating of the interrupt line
    cur_req = "R8";
    pin_in = 16'h0000; repeat (3) cycle();
    pin_in = 16'h0810; repeat (4) cycle();
    wr(0, 16'hFFEF); cycle();
    wr(0, 16'hF7EF); cycle();
    wr(0, 16'h0000); cycle();
    wr(9, 16'hFFFF); rd(9);

    // R9: sleep levels with exclusion
    cur_req = "R9";
    wr(2, 16'h0000); wr(7, 16'hFFFF); wr(6, 16'h00FF);
    sleep = 1'b1; repeat (2) cycle();
    wr(7, 16'h5A5A); cycle();
    sleep = 1'b0; cycle();

    // R10: forced sleep levels without sleep_i
    cur_req = "R10";
    wr(11, 16'h0002); repeat (2) cycle();
    wr(11, 16'h0000); cycle();

    // R11: fault levels, also against sleep
    cur_req = "R11";
    wr(8, 16'hC3C3);
    batt = 1'b1; repeat (2) cycle();
    sleep = 1'b1; repeat (2) cycle();
    wr(11, 16'h0002); cycle();
    batt = 1'b0; cycle();
    sleep = 1'b0; wr(11, 16'h0000); cycle();

    // R7: random traffic including clear/detect collisions
    cur_req = "R7";
    for (int n = 0; n < 3000; n++) begin
      pin_in = ($urandom_range(0, 3) == 0) ? NP'($urandom) : pin_in;
      sleep  = ($urandom_range(0, 7) == 0);
      batt   = ($urandom_range(0, 15) == 0);
      addr   = 4'($urandom_range(0, 15));
      we     = ($urandom_range(0, 2) == 0) && (addr != 4'd1 || $urandom_range(0, 1) == 0);
      wdata  = NP'($urandom);
      cycle();
    end
    we = 1'b0;
    cycle();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule